// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This block gathers the interrupt sources of a small microcontroller into one request line for the core. Three core sources are handled in a control register that also holds the global enable and the peripheral-group enable: a timer overflow, an external edge and a port-change detector. The remaining sources sit in two peripheral flag/enable register pairs. Each flag latches when its event pulse arrives and stays set until software writes it clear. A core source reaches the request line through its own enable and the global enable. A peripheral source must also pass the peripheral-group enable.

The port-change detector compares a group of input pins against a snapshot of those pins. The snapshot is reloaded only when software reads the port. As long as the pins differ from the snapshot, the detector keeps setting its flag. When the core takes the interrupt it pulses an acknowledge, and the block drops the global enable. A return-from-interrupt strobe sets the global enable again.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every flag, enable and pin snapshot is zero, all read values are zero (with the level inputs low) and `irq_o` is low.
- R2: Control register bit positions: 7 global enable, 6 peripheral-group enable, 5 timer enable, 4 external enable, 3 port-change enable, 2 timer flag, 1 external flag, 0 port-change flag. A write stores all eight bits and the value reads back unchanged.
- R3: A source event sets its flag on the next clock edge. This happens whatever the state of the source's own enable, the group enable or the global enable.
- R4: A flag stays set until software writes a 0 to it, and that write clears it.
- R5: When a software clear and a new event hit the same flag in the same cycle, the flag ends up set.
- R6: The port-change flag is set while any of the `PIN_W` pins differs from the snapshot, so a clear does not stick during a mismatch. A `port_rd_i` strobe loads the snapshot from the pins, and after that a clear sticks until a pin changes again.
- R7: Peripheral flag bit positions: 7 parallel port, 6 converter, 5 receive-buffer full, 4 transmit-buffer empty, 3 serial port, 2 capture/compare 1, 1 timer match, 0 timer overflow. Bits 5 and 4 read the `periph_lvl_i` levels directly; writes and events to those two bits have no effect.
- R8: In the auxiliary flag/enable pair only bits 6 (comparator), 4 (write complete), 3 (bus collision) and 0 (capture/compare 2) exist. Every other bit reads 0 and ignores writes and events.
- R9: `irq_o` is high when the global enable is set and at least one core flag has its enable set. It rises in the cycle after the event edge.
- R10: A peripheral flag that has its enable set raises `irq_o` only when the global enable and the group enable are both set.
- R11: `ack_i` clears the global enable on the next edge, and this wins over a control write in the same cycle. `reti_i` sets the global enable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_evt_i | input | 1 | Timer overflow event pulse |
| ext_evt_i | input | 1 | External edge event pulse |
| pins_i | input | PIN_W | Watched port pins |
| port_rd_i | input | 1 | Port read strobe, reloads the snapshot |
| periph_evt_i | input | 8 | Peripheral event pulses, by flag bit |
| periph_lvl_i | input | 8 | Buffer status levels for the level bits |
| aux_evt_i | input | 8 | Auxiliary event pulses, by flag bit |
| ack_i | input | 1 | Core vectors to the interrupt |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ctl_we_i | input | 1 | Control register write |
| ctl_wdata_i | input | 8 | Control register write data |
| pflag_we_i | input | 1 | Peripheral flag write |
| pflag_wdata_i | input | 8 | Peripheral flag write data |
| pen_we_i | input | 1 | Peripheral enable write |
| pen_wdata_i | input | 8 | Peripheral enable write data |
| aflag_we_i | input | 1 | Auxiliary flag write |
| aflag_wdata_i | input | 8 | Auxiliary flag write data |
| aen_we_i | input | 1 | Auxiliary enable write |
| aen_wdata_i | input | 8 | Auxiliary enable write data |
| irq_o | output | 1 | Interrupt request to the core |
| ctl_rdata_o | output | 8 | Control register read value |
| pflag_rdata_o | output | 8 | Peripheral flag read value |
| pen_rdata_o | output | 8 | Peripheral enable read value |
| aflag_rdata_o | output | 8 | Auxiliary flag read value |
| aen_rdata_o | output | 8 | Auxiliary enable read value |

## Verification
The bench builds the block with its default parameters. These are four watched pins, receive and transmit levels at bits 5 and 4, and auxiliary bits 6, 4, 3 and 0 implemented. With this setup one test can check every peripheral bit position, both level bits and all four unimplemented auxiliary holes. Moving each pin of the four-pin snapshot in turn lets the bench check that a change on any pin keeps the port-change flag alive until the port is read.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int REG_W = 8;

    // Control register, MSB first: the bit order is fixed by software decode.
    typedef struct packed {
        logic gie;
        logic peie;
        logic tick_en;
        logic ext_en;
        logic pin_en;
        logic tick_fl;
        logic ext_fl;
        logic pin_fl;
    } ctl_t;
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
    parameter int         W     = 8,
    parameter logic [W-1:0] IMPL  = '1,
    parameter logic [W-1:0] LEVEL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] lvl_i,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] flags_o
);
    localparam logic [W-1:0] STICKY = IMPL & ~LEVEL;
    localparam logic [W-1:0] LVLIMP = IMPL & LEVEL;

    logic [W-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (we_i) flag_d = wdata_i;
        // an event in the same cycle as a clear keeps the flag set
        flag_d = (flag_d | evt_i) & STICKY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags_o = flag_q | (lvl_i & LVLIMP);
endmodule

// File: rtl/irq_pin_watch.sv
module irq_pin_watch #(
    parameter int PIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pins_i,
    input  logic             port_rd_i,
    output logic             mismatch_o
);
    logic [PIN_W-1:0] snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (port_rd_i) snap_d = pins_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign mismatch_o = |(pins_i ^ snap_q);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_pkg::*;
#(
    parameter int               PIN_W      = 4,
    parameter logic [REG_W-1:0] PERIPH_LVL = 8'h30,
    parameter logic [REG_W-1:0] AUX_IMPL   = 8'h59
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_evt_i,
    input  logic             ext_evt_i,
    input  logic [PIN_W-1:0] pins_i,
    input  logic             port_rd_i,
    input  logic [REG_W-1:0] periph_evt_i,
    input  logic [REG_W-1:0] periph_lvl_i,
    input  logic [REG_W-1:0] aux_evt_i,
    input  logic             ack_i,
    input  logic             reti_i,
    input  logic             ctl_we_i,
    input  logic [REG_W-1:0] ctl_wdata_i,
    input  logic             pflag_we_i,
    input  logic [REG_W-1:0] pflag_wdata_i,
    input  logic             pen_we_i,
    input  logic [REG_W-1:0] pen_wdata_i,
    input  logic             aflag_we_i,
    input  logic [REG_W-1:0] aflag_wdata_i,
    input  logic             aen_we_i,
    input  logic [REG_W-1:0] aen_wdata_i,
    output logic             irq_o,
    output logic [REG_W-1:0] ctl_rdata_o,
    output logic [REG_W-1:0] pflag_rdata_o,
    output logic [REG_W-1:0] pen_rdata_o,
    output logic [REG_W-1:0] aflag_rdata_o,
    output logic [REG_W-1:0] aen_rdata_o
);
    typedef struct packed {
        ctl_t             ctl;
        logic [REG_W-1:0] pen;
        logic [REG_W-1:0] aen;
    } state_t;

    state_t st_d, st_q;
    logic   pin_mismatch;
    logic [REG_W-1:0] pflags, aflags;
    logic   core_hit, per_hit;

    irq_pin_watch #(.PIN_W(PIN_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_i     (pins_i),
        .port_rd_i  (port_rd_i),
        .mismatch_o (pin_mismatch)
    );

    irq_flag_reg #(.W(REG_W), .IMPL('1), .LEVEL(PERIPH_LVL)) u_pflag (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (periph_evt_i),
        .lvl_i   (periph_lvl_i),
        .we_i    (pflag_we_i),
        .wdata_i (pflag_wdata_i),
        .flags_o (pflags)
    );

    irq_flag_reg #(.W(REG_W), .IMPL(AUX_IMPL), .LEVEL('0)) u_aflag (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (aux_evt_i),
        .lvl_i   ('0),
        .we_i    (aflag_we_i),
        .wdata_i (aflag_wdata_i),
        .flags_o (aflags)
    );

    always_comb begin
        st_d = st_q;
        if (ctl_we_i) st_d.ctl = ctl_t'(ctl_wdata_i);
        st_d.ctl.tick_fl = st_d.ctl.tick_fl | tick_evt_i;
        st_d.ctl.ext_fl  = st_d.ctl.ext_fl  | ext_evt_i;
        st_d.ctl.pin_fl  = st_d.ctl.pin_fl  | pin_mismatch;
        if (reti_i) st_d.ctl.gie = 1'b1;
        if (ack_i)  st_d.ctl.gie = 1'b0;
        if (pen_we_i) st_d.pen = pen_wdata_i;
        if (aen_we_i) st_d.aen = aen_wdata_i & AUX_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign core_hit = |({st_q.ctl.tick_en, st_q.ctl.ext_en, st_q.ctl.pin_en} &
                        {st_q.ctl.tick_fl, st_q.ctl.ext_fl, st_q.ctl.pin_fl});
    assign per_hit  = (|(pflags & st_q.pen)) | (|(aflags & st_q.aen));
    assign irq_o    = st_q.ctl.gie & (core_hit | (st_q.ctl.peie & per_hit));

    assign ctl_rdata_o   = st_q.ctl;
    assign pflag_rdata_o = pflags;
    assign pen_rdata_o   = st_q.pen;
    assign aflag_rdata_o = aflags;
    assign aen_rdata_o   = st_q.aen;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter logic [7:0] PERIPH_LVL = 8'h30
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ack_i,
    input logic       reti_i,
    input logic       pflag_we_i,
    input logic [7:0] periph_evt_i,
    input logic       irq_o,
    input logic [7:0] ctl_rdata_o,
    input logic [7:0] pflag_rdata_o
);
    localparam logic [7:0] STICKY = ~PERIPH_LVL;

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pflag_we_i |=> ((($past(pflag_rdata_o) & ~pflag_rdata_o) & STICKY) == 8'h00));

    assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(periph_evt_i & STICKY)) |=>
        ((pflag_rdata_o & $past(periph_evt_i & STICKY)) == $past(periph_evt_i & STICKY)));

    assert_ack_drops_gie_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !ctl_rdata_o[7]);

    assert_reti_sets_gie_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !ack_i) |=> ctl_rdata_o[7]);

    assert_irq_needs_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctl_rdata_o[7]);

    assert_no_group_core_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ctl_rdata_o[6]) |-> (|(ctl_rdata_o[5:3] & ctl_rdata_o[2:0])));
endmodule

bind irq_aggregator irq_aggregator_chk #(.PERIPH_LVL(PERIPH_LVL)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ack_i         (ack_i),
    .reti_i        (reti_i),
    .pflag_we_i    (pflag_we_i),
    .periph_evt_i  (periph_evt_i),
    .irq_o         (irq_o),
    .ctl_rdata_o   (ctl_rdata_o),
    .pflag_rdata_o (pflag_rdata_o)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_evt_i = 0, ext_evt_i = 0, port_rd_i = 0, ack_i = 0, reti_i = 0;
    logic [3:0] pins_i = '0;
    logic [7:0] periph_evt_i = '0, periph_lvl_i = '0, aux_evt_i = '0;
    logic       ctl_we_i = 0, pflag_we_i = 0, pen_we_i = 0, aflag_we_i = 0, aen_we_i = 0;
    logic [7:0] ctl_wdata_i = '0, pflag_wdata_i = '0, pen_wdata_i = '0;
    logic [7:0] aflag_wdata_i = '0, aen_wdata_i = '0;
    logic       irq_o;
    logic [7:0] ctl_rdata_o, pflag_rdata_o, pen_rdata_o, aflag_rdata_o, aen_rdata_o;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_aggregator i_irq_aggregator (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        tick_evt_i = 0; ext_evt_i = 0; port_rd_i = 0; ack_i = 0; reti_i = 0;
        periph_evt_i = '0; aux_evt_i = '0;
        ctl_we_i = 0; pflag_we_i = 0; pen_we_i = 0; aflag_we_i = 0; aen_we_i = 0;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_we_i = 1; ctl_wdata_i = v; step(); idle();
    endtask

    task automatic do_reset();
        idle(); pins_i = '0; periph_lvl_i = '0;
        rst_n = 0; step(); step(); rst_n = 1; step();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 ctl", ctl_rdata_o, 8'h00);
        chk("R1 pflag", pflag_rdata_o, 8'h00);
        chk("R1 pen", pen_rdata_o, 8'h00);
        chk("R1 aflag", aflag_rdata_o, 8'h00);
        chk("R1 aen", aen_rdata_o, 8'h00);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_ctl_rw();
        do_reset();
        wr_ctl(8'h78);
        chk("R2 readback 78", ctl_rdata_o, 8'h78);
        wr_ctl(8'h06);
        chk("R2 readback 06", ctl_rdata_o, 8'h06);
    endtask

    task automatic t_flags_set_hold();
        do_reset();
        tick_evt_i = 1; step(); idle();
        chk("R3 timer flag bit2 with enables off", ctl_rdata_o, 8'h04);
        ext_evt_i = 1; step(); idle();
        chk("R3 external flag bit1", ctl_rdata_o, 8'h06);
        periph_evt_i = 8'h81; step(); idle();
        chk("R3 peripheral flags", pflag_rdata_o, 8'h81);
        step(); step();
        chk("R4 flags held", ctl_rdata_o, 8'h06);
        chk("R4 peripheral held", pflag_rdata_o, 8'h81);
        pflag_we_i = 1; pflag_wdata_i = 8'h01; step(); idle();
        chk("R4 write clears bit7", pflag_rdata_o, 8'h01);
    endtask

    task automatic t_clear_vs_event();
        do_reset();
        periph_evt_i = 8'h02; step(); idle();
        pflag_we_i = 1; pflag_wdata_i = 8'h00; periph_evt_i = 8'h02; step(); idle();
        chk("R5 event beats clear", pflag_rdata_o, 8'h02);
        tick_evt_i = 1; step(); idle();
        ctl_we_i = 1; ctl_wdata_i = 8'h00; tick_evt_i = 1; step(); idle();
        chk("R5 core event beats clear", ctl_rdata_o, 8'h04);
    endtask

    task automatic t_pin_change();
        do_reset();
        for (int p = 0; p < 4; p++) begin
            pins_i = 4'b1 << p; step();
            chk($sformatf("R6 pin %0d sets flag", p), ctl_rdata_o & 8'h01, 8'h01);
            wr_ctl(8'h00);
            chk($sformatf("R6 pin %0d clear refused", p), ctl_rdata_o & 8'h01, 8'h01);
            port_rd_i = 1; step(); idle();
            wr_ctl(8'h00);
            step();
            chk($sformatf("R6 pin %0d clear sticks", p), ctl_rdata_o & 8'h01, 8'h00);
            pins_i = '0; step();
            port_rd_i = 1; step(); idle();
            wr_ctl(8'h00);
        end
    endtask

    task automatic t_periph_levels();
        do_reset();
        pflag_we_i = 1; pflag_wdata_i = 8'hFF; step(); idle();
        chk("R7 write skips level bits", pflag_rdata_o, 8'hCF);
        periph_lvl_i = 8'h30; step();
        chk("R7 level bits follow inputs", pflag_rdata_o, 8'hFF);
        periph_lvl_i = 8'h10; pflag_we_i = 1; pflag_wdata_i = 8'h00;
        periph_evt_i = 8'h20; step(); idle();
        chk("R7 receive level only", pflag_rdata_o, 8'h10);
    endtask

    task automatic t_aux();
        do_reset();
        aflag_we_i = 1; aflag_wdata_i = 8'hFF; aen_we_i = 1; aen_wdata_i = 8'hFF; step(); idle();
        chk("R8 aux flag write", aflag_rdata_o, 8'h59);
        chk("R8 aux enable write", aen_rdata_o, 8'h59);
        aflag_we_i = 1; aflag_wdata_i = 8'h00; step(); idle();
        aux_evt_i = 8'hA6; step(); idle();
        chk("R8 holes ignore events", aflag_rdata_o, 8'h00);
    endtask

    task automatic t_irq_core();
        do_reset();
        wr_ctl(8'h20);
        tick_evt_i = 1; step(); idle();
        chk("R9 no irq without global enable", {7'b0, irq_o}, 8'h00);
        wr_ctl(8'hA4);
        chk("R9 irq with global and timer enable", {7'b0, irq_o}, 8'h01);
        wr_ctl(8'h90);
        chk("R9 flag cleared drops irq", {7'b0, irq_o}, 8'h00);
        ext_evt_i = 1; step(); idle();
        chk("R9 external raises irq next cycle", {7'b0, irq_o}, 8'h01);
    endtask

    task automatic t_irq_periph();
        do_reset();
        pen_we_i = 1; pen_wdata_i = 8'h01; step(); idle();
        wr_ctl(8'h80);
        periph_evt_i = 8'h01; step(); idle();
        chk("R10 group enable off blocks", {7'b0, irq_o}, 8'h00);
        wr_ctl(8'hC0);
        chk("R10 group enable on passes", {7'b0, irq_o}, 8'h01);
        pflag_we_i = 1; pflag_wdata_i = 8'h00; aen_we_i = 1; aen_wdata_i = 8'h40;
        aux_evt_i = 8'h40; step(); idle();
        chk("R10 aux comparator passes", {7'b0, irq_o}, 8'h01);
    endtask

    task automatic t_ack_reti();
        do_reset();
        wr_ctl(8'hA0);
        tick_evt_i = 1; step(); idle();
        chk("R11 irq before ack", {7'b0, irq_o}, 8'h01);
        ack_i = 1; step(); idle();
        chk("R11 ack clears global enable", ctl_rdata_o, 8'h24);
        chk("R11 irq low after ack", {7'b0, irq_o}, 8'h00);
        reti_i = 1; step(); idle();
        chk("R11 reti restores", ctl_rdata_o, 8'hA4);
        ack_i = 1; ctl_we_i = 1; ctl_wdata_i = 8'hA4; step(); idle();
        chk("R11 ack beats write", ctl_rdata_o, 8'h24);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_ctl_rw();
        t_flags_set_hold();
        t_clear_vs_event();
        t_pin_change();
        t_periph_levels();
        t_aux();
        t_irq_core();
        t_irq_periph();
        t_ack_reti();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule